// File: doc/BRIEF.md
# Radix-4 Sequential Multiplier with Carry-Based Digit Selection

This block multiplies two unsigned WIDTH-bit operands and produces their full 2·WIDTH-bit product. It retires two multiplier bits per clock. The multiple that is added for each bit pair comes only from the set {0, a, 2a, -a}. Pair value 3 (and pair value 2 with a pending carry) is rewritten as -a now plus a carry of one into the next pair. No 3a multiple is ever formed, and no cycle is spent precomputing one.

Each step adds the selected multiple to the upper part of a partial-product accumulator. That part carries signed guard bits, so a -a step stays correct. The whole accumulator then moves right by two places. Once every bit pair is consumed, one correction step adds a into the upper half if a carry is still pending. The product is then exact. The correction step is always taken, so the latency is the same for every operand pair.

A caller presents operands with a single-cycle `start` while the unit is idle. The caller then waits for the one-cycle `done` pulse. The product stays on its output until the next accepted start.

Top module: `radix4_carry_mult`

## Requirements
- R1: After reset, `done` is 0 and `product` is 0.
- R2: For any unsigned operands, the `product` shown with `done` equals a_in × x_in, where a_in and x_in are the values sampled with the accepted start. This covers zero and all-ones operands.
- R3: `done` is high for exactly one cycle. It is high after rising edge number WIDTH/2+2, counting the edge that samples `start` as edge 1. That is WIDTH/2 digit steps plus one correction step.
- R4: Each digit step maps (pair bits x_{i+1}, x_i, incoming carry c) to a 2-bit control and a carry-out. Control code 00 selects 0, 01 selects a, 10 selects 2a, and 11 selects -a. The control's low bit is x_i XOR c, and its high bit is x_{i+1} XOR (x_i AND c). The carry-out is x_{i+1} AND (x_i OR c). The carry is 0 at the first pair. So the selected digit plus four times the carry-out always equals the pair value plus c.
- R5: A carry still pending after the last bit pair adds a·2^WIDTH in the correction step. For example, a multiplier whose top pair is 11 still gives the exact product.
- R6: A `start` raised while a multiplication is in progress is ignored. The running operation finishes on time with its original operands.
- R7: While idle and without a new start, `product` holds its value, even if `a_in` and `x_in` change.
- R8: When `done` is high, the guard bits above the upper half of the accumulator are zero. The result fits in 2·WIDTH bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication; accepted only while idle |
| a_in | input | WIDTH | Unsigned multiplicand |
| x_in | input | WIDTH | Unsigned multiplier |
| product | output | 2*WIDTH | Unsigned product, valid from `done` until the next accepted start |
| done | output | 1 | One-cycle pulse when `product` is valid |

## Verification
On every digit step, the assertions check the selector's arithmetic balance between digit, carry-out, bit pair and carry-in. They also check the exact `done` latency and pulse width, that `product` holds while idle, and that the guard bits are clear at completion. Only the bench's scenarios can show that the final product is numerically right for chosen operands. The same goes for the carry-out correction on multipliers with a high top pair, and for a mid-run start being ignored while the original operands are kept.

// File: rtl/r4cm_pkg.sv
package r4cm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIX  = 2'b10
  } r4cm_state_e;

  // Control code for the multiple mux (R4)
  typedef enum logic [1:0] {
    SEL_ZERO = 2'b00,
    SEL_ONE  = 2'b01,
    SEL_TWO  = 2'b10,
    SEL_NEG  = 2'b11
  } r4cm_ctl_e;

  typedef struct packed {
    r4cm_ctl_e ctl;
    logic      carry;
  } r4cm_sel_t;

  // Digit selection from the bit pair and the incoming carry
  function automatic r4cm_sel_t r4cm_select(input logic [1:0] pair, input logic cin);
    r4cm_sel_t s;
    s.ctl   = r4cm_ctl_e'({pair[1] ^ (pair[0] & cin), pair[0] ^ cin});
    s.carry = pair[1] & (pair[0] | cin);
    return s;
  endfunction

  // Signed digit weight of a control code
  function automatic int r4cm_digit_value(input r4cm_ctl_e ctl);
    case (ctl)
      SEL_ONE: return 1;
      SEL_TWO: return 2;
      SEL_NEG: return -1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/r4cm_digit_sel.sv
module r4cm_digit_sel
  import r4cm_pkg::*;
(
  input  logic [1:0] pair,
  input  logic       cin,
  output r4cm_ctl_e  ctl,
  output logic       cout
);
  r4cm_sel_t sel;

  always_comb begin
    sel  = r4cm_select(pair, cin);
    ctl  = sel.ctl;
    cout = sel.carry;
  end
endmodule

// File: rtl/r4cm_multiple_mux.sv
module r4cm_multiple_mux
  import r4cm_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int ACC_W = WIDTH + 3
) (
  input  logic [WIDTH-1:0]        a,
  input  r4cm_ctl_e               ctl,
  output logic signed [ACC_W-1:0] mult
);
  logic signed [ACC_W-1:0] a_ext;

  assign a_ext = $signed({{(ACC_W-WIDTH){1'b0}}, a});

  always_comb begin
    case (ctl)
      SEL_ONE: mult = a_ext;
      SEL_TWO: mult = a_ext <<< 1;
      SEL_NEG: mult = -a_ext;
      default: mult = '0;
    endcase
  end
endmodule

// File: rtl/r4cm_accum.sv
module r4cm_accum #(
  parameter int WIDTH = 8,
  parameter int ACC_W = WIDTH + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    step,
  input  logic                    fix,
  input  logic signed [ACC_W-1:0] mult,
  output logic signed [ACC_W-1:0] hi,
  output logic [WIDTH-1:0]        lo
);
  logic signed [ACC_W-1:0] sum;

  assign sum = hi + mult;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi <= '0;
      lo <= '0;
    end else if (clear) begin
      hi <= '0;
      lo <= '0;
    end else if (step) begin
      hi <= sum >>> 2;
      lo <= {sum[1:0], lo[WIDTH-1:2]};
    end else if (fix) begin
      hi <= sum;
    end
  end
endmodule

// File: rtl/radix4_carry_mult.sv
module radix4_carry_mult
  import r4cm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [WIDTH-1:0]     a_in,
  input  logic [WIDTH-1:0]     x_in,
  output logic [2*WIDTH-1:0]   product,
  output logic                 done
);
  localparam int DIGITS = WIDTH / 2;
  localparam int ACC_W  = WIDTH + 3;
  localparam int CNT_W  = $clog2(DIGITS + 1);

  r4cm_state_e             state_q;
  logic [WIDTH-1:0]        a_q;
  logic [WIDTH-1:0]        x_q;
  logic                    carry_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    done_q;

  // Named internal events for the checker
  logic                    busy_w;
  logic                    accept_w;
  logic                    step_w;
  logic                    fix_w;
  logic [1:0]              pair_w;
  r4cm_ctl_e               sel_ctl_w;
  r4cm_ctl_e               mux_ctl_w;
  logic                    cout_w;
  logic signed [ACC_W-1:0] mult_w;
  logic signed [ACC_W-1:0] hi_w;
  logic [WIDTH-1:0]        lo_w;
  logic [ACC_W-WIDTH-1:0]  hi_guard_w;

  assign busy_w     = (state_q != ST_IDLE);
  assign accept_w   = start && !busy_w;
  assign step_w     = (state_q == ST_RUN);
  assign fix_w      = (state_q == ST_FIX);
  assign pair_w     = x_q[1:0];
  assign hi_guard_w = hi_w[ACC_W-1:WIDTH];

  r4cm_digit_sel u_sel (
    .pair (pair_w),
    .cin  (carry_q),
    .ctl  (sel_ctl_w),
    .cout (cout_w)
  );

  // The correction step reuses the mux: add a if a carry is pending
  always_comb begin
    if (fix_w) mux_ctl_w = carry_q ? SEL_ONE : SEL_ZERO;
    else       mux_ctl_w = step_w ? sel_ctl_w : SEL_ZERO;
  end

  r4cm_multiple_mux #(.WIDTH(WIDTH), .ACC_W(ACC_W)) u_mux (
    .a    (a_q),
    .ctl  (mux_ctl_w),
    .mult (mult_w)
  );

  r4cm_accum #(.WIDTH(WIDTH), .ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept_w),
    .step  (step_w),
    .fix   (fix_w),
    .mult  (mult_w),
    .hi    (hi_w),
    .lo    (lo_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      a_q     <= '0;
      x_q     <= '0;
      carry_q <= 1'b0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fix_w;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            a_q     <= a_in;
            x_q     <= x_in;
            carry_q <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          x_q     <= x_q >> 2;
          carry_q <= cout_w;
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DIGITS - 1)) state_q <= ST_FIX;
        end
        ST_FIX: begin
          carry_q <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign product = {hi_w[WIDTH-1:0], lo_w};
  assign done    = done_q;
endmodule

// File: rtl/r4cm_mult_chk.sv
module r4cm_mult_chk
  import r4cm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   done,
  input logic [2*WIDTH-1:0]     product,
  input logic                   busy,
  input logic                   step,
  input logic [1:0]             pair,
  input logic                   cin,
  input r4cm_ctl_e              ctl,
  input logic                   cout,
  input logic [2:0]             hi_guard
);
  localparam int DIGITS = WIDTH / 2;

  int unsigned lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              lat_cnt <= 0;
    else if (start && !busy) lat_cnt <= 1;
    else if (busy)           lat_cnt <= lat_cnt + 1;
  end

  // R4: digit + 4*carry-out balances pair + carry-in
  p_digit_balance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (r4cm_digit_value(ctl) + 4 * int'(cout)) == (int'(pair) + int'(cin)));

  // R3: done comes a fixed number of edges after acceptance
  p_done_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat_cnt == DIGITS + 2);

  // R3: done lasts one cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: product holds while idle without a start
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  // R8: no guard bits left set at completion
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> hi_guard == 3'b000);
endmodule

bind radix4_carry_mult r4cm_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .done     (done),
  .product  (product),
  .busy     (busy_w),
  .step     (step_w),
  .pair     (pair_w),
  .cin      (carry_q),
  .ctl      (sel_ctl_w),
  .cout     (cout_w),
  .hi_guard (hi_guard_w)
);

// File: tb/tb_radix4_carry_mult.sv
module tb_radix4_carry_mult;
  localparam int WIDTH   = 8;
  localparam int CLK_PER = 10;
  localparam int LAT     = WIDTH / 2 + 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [WIDTH-1:0]   a_in = '0;
  logic [WIDTH-1:0]   x_in = '0;
  logic [2*WIDTH-1:0] product;
  logic               done;

  int checks = 0;
  int fails  = 0;
  logic [15:0] lfsr = 16'hACE1;

  radix4_carry_mult #(.WIDTH(WIDTH)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_in(a_in), .x_in(x_in), .product(product), .done(done)
  );

  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference product by plain binary shift-and-add
  function automatic logic [2*WIDTH-1:0] ref_mul(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] x);
    logic [2*WIDTH-1:0] acc = '0;
    for (int i = 0; i < WIDTH; i++)
      if (x[i]) acc = acc + ({{WIDTH{1'b0}}, a} << i);
    return acc;
  endfunction

  task automatic run_mul(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] x, input string req);
    int edges;
    logic [2*WIDTH-1:0] exp;
    exp = ref_mul(a, x);
    @(negedge clk);
    a_in = a; x_in = x; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    while (!done && edges < 60) begin
      @(negedge clk);
      edges++;
    end
    check(edges == LAT, {req, " R3 latency"}, edges, LAT);
    check(product == exp, {req, " R2 product"}, product, exp);
    @(negedge clk);
    check(done == 1'b0, "R3 single-cycle done", done, 0);
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(product == '0, "R1 product after reset", product, 0);
  endtask

  task automatic t_corners();
    run_mul(8'd0,   8'd0,   "R2 zero*zero");
    run_mul(8'd255, 8'd255, "R2 R5 max*max");
    run_mul(8'd0,   8'd255, "R2 zero*max");
    run_mul(8'd255, 8'd1,   "R2 max*one");
    run_mul(8'd1,   8'd255, "R2 one*max");
  endtask

  task automatic t_selector();
    // pairs covering every (x1,x0,c) combination
    run_mul(8'd201, 8'h55, "R4 pairs 01");
    run_mul(8'd201, 8'hAA, "R4 pairs 10");
    run_mul(8'd201, 8'h1B, "R4 pairs 00 01 10 11");
    run_mul(8'd173, 8'hE4, "R4 pairs 11 10 01 00");
    run_mul(8'd77,  8'h03, "R4 single 11 pair");
    run_mul(8'd99,  8'h66, "R4 mixed carries");
  endtask

  task automatic t_final_carry();
    run_mul(8'd250, 8'hC0, "R5 top pair 11");
    run_mul(8'd131, 8'h80, "R5 top pair 10 with no carry");
    run_mul(8'd17,  8'hBF, "R5 carry chain into top");
  endtask

  task automatic t_busy_start();
    int edges;
    logic [2*WIDTH-1:0] exp;
    exp = ref_mul(8'd123, 8'd222);
    @(negedge clk);
    a_in = 8'd123; x_in = 8'd222; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    @(negedge clk); edges++;
    a_in = 8'd9; x_in = 8'd7; start = 1'b1;
    @(negedge clk); edges++;
    start = 1'b0;
    while (!done && edges < 60) begin
      @(negedge clk);
      edges++;
    end
    check(edges == LAT, "R6 latency with mid-run start", edges, LAT);
    check(product == exp, "R6 product keeps first operands", product, exp);
  endtask

  task automatic t_hold();
    logic [2*WIDTH-1:0] held;
    run_mul(8'd45, 8'd210, "R7 setup");
    held = product;
    a_in = 8'd3; x_in = 8'd5;
    repeat (6) @(negedge clk);
    check(product == held, "R7 product held while idle", product, held);
  endtask

  task automatic t_random();
    for (int n = 0; n < 120; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_mul(lfsr[7:0], lfsr[15:8], "R2 R4 pseudo-random");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_corners();
    t_selector();
    t_final_carry();
    t_busy_start();
    t_hold();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule